// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins coming from outside the chip and turns them into clean, clocked interrupt requests for a parent interrupt controller. Each pin is first brought into the clock domain through a two-stage synchroniser. It is then checked against its own detection mode: falling edge, rising edge, both edges, low level or high level. A detected event sets a pending latch for that pin. The request reaches the parent only while the pin is unmasked and has a nonzero priority.

Software programs the block through a simple word-wide register port with six locations: sense modes, priorities, pending sources, mask set, mask clear and a mode-control word. Pins are numbered from the most significant end in every register, so pin 0 always sits in the highest field. The block drives one request line per pin and also the OR of all of them. A parent with one line per pin and a parent with a single shared line can both use it.

Top module: `extirq_pin_ctrl`

## Requirements
- R1: A level change on a pin is seen by the pending logic after two synchroniser stages. After a pin change the pending bit is still clear after two rising clock edges and is set after the third.
- R2: Sense code 0 sets the pin's pending bit on a high-to-low transition of the synchronised pin, and never on a low-to-high one.
- R3: Sense code 1 sets the pending bit on a low-to-high transition, and never on a high-to-low one.
- R4: Sense code 3 (high level) and code 2 (low level) set the pending bit on every clock while the level is active. A clear written while the level is active leaves the bit set. A clear written after the pin goes inactive removes it.
- R5: Sense code 4 sets the pending bit on both transitions.
- R6: Sense codes 5 to 15 disable detection, so the pending bit never sets whatever the pin does.
- R7: The sense word at address 0 holds pin n's field at bit offset 32-(n+1)*SENSE_W (4-bit fields by default). The word reads back as written.
- R8: The priority word at address 1 holds pin n's 4-bit field at bits 31-4n down to 28-4n. It reads back as written. A zero field blocks that pin's request, and any nonzero value passes it.
- R9: A 1 written to pin n's bit in the mask-set location (address 3) masks that pin. A 1 written to the same bit in the mask-clear location (address 4) unmasks it. Zeros have no effect, and both locations read as zero.
- R10: The source location (address 2) shows pin n's pending bit at bit SRC_W-1-n (bit 7-n by default). A write clears each pending bit whose written bit is 0 and leaves bits written as 1 unchanged.
- R11: irq_req[n] is high exactly while pin n is pending, unmasked and of nonzero priority. irq_any is the OR of irq_req.
- R12: The control location (address 5) stores only bit 23, the individual-pin mode select. All other bits read as zero, and bit 23 resets to 0.
- R13: After reset all pins are masked, all priorities and sense fields are zero, no bit is pending, and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins, bit n is pin n |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register location: 0 sense, 1 priority, 2 source, 3 mask set, 4 mask clear, 5 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_req | output | NUM_PINS | Per-pin request to the parent, bit n is pin n |
| irq_any | output | 1 | OR of all per-pin requests for a shared parent line |

## Verification
A pin change made between edges shows up in the pending bit and on irq_req after the third rising edge: two edges go to the synchroniser and one to the pending latch. The bench therefore samples two falling edges after the change to see the bit still clear, and three falling edges after it to see the bit set. A register write presented before an edge takes effect at that edge. Its effect on irq_req, or on the combinational read data, is checked at the following falling edge. Level-mode tests wait at least four edges after the pin goes inactive before they issue the clear, so the synchroniser has drained.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  localparam int MAX_PINS      = 8;
  localparam int PRIO_W        = 4;
  localparam int WORD_W        = 32;
  localparam int CTRL_MODE_BIT = 23;

  typedef enum logic [2:0] {
    A_SENSE = 3'd0,
    A_PRIO  = 3'd1,
    A_SRC   = 3'd2,
    A_MSET  = 3'd3,
    A_MCLR  = 3'd4,
    A_CTRL  = 3'd5
  } reg_addr_e;

  localparam logic [3:0] S_FALL = 4'd0;
  localparam logic [3:0] S_RISE = 4'd1;
  localparam logic [3:0] S_LOW  = 4'd2;
  localparam logic [3:0] S_HIGH = 4'd3;
  localparam logic [3:0] S_BOTH = 4'd4;

  // Lowest bit of pin n's field in an MSB-first packed word.
  function automatic int field_lsb(input int pin, input int fw);
    return WORD_W - (pin + 1) * fw;
  endfunction

  // Bit position of pin n in a one-bit-per-pin register of width w.
  function automatic int src_pos(input int pin, input int w);
    return w - 1 - pin;
  endfunction

  function automatic logic code_ok(input logic [3:0] code);
    return (code <= S_BOTH);
  endfunction

  function automatic logic detect(input logic [3:0] code, input logic prev,
                                  input logic cur);
    logic hit;
    case (code)
      S_FALL:  hit = prev & ~cur;
      S_RISE:  hit = ~prev & cur;
      S_LOW:   hit = ~cur;
      S_HIGH:  hit = cur;
      S_BOTH:  hit = prev ^ cur;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic [3:0] code,
  output logic       event_hit,
  output logic       code_valid
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sample;
  end

  assign event_hit  = detect(code, prev_q, sample);
  assign code_valid = code_ok(code);

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int SRC_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [2:0]          reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] evt_vec,
  output logic [NUM_PINS*4-1:0] code_flat,
  output logic [NUM_PINS-1:0] pend_vec,
  output logic [NUM_PINS-1:0] mask_vec,
  output logic [NUM_PINS-1:0] prio_nz_vec
);

  logic [SENSE_W-1:0] sense_q [NUM_PINS];
  logic [PRIO_W-1:0]  prio_q  [NUM_PINS];
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] pend_q;
  logic               mode_q;

  logic wr_sense, wr_prio, wr_src, wr_mset, wr_mclr, wr_ctrl;

  assign wr_sense = reg_we && (reg_addr == A_SENSE);
  assign wr_prio  = reg_we && (reg_addr == A_PRIO);
  assign wr_src   = reg_we && (reg_addr == A_SRC);
  assign wr_mset  = reg_we && (reg_addr == A_MSET);
  assign wr_mclr  = reg_we && (reg_addr == A_MCLR);
  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);

  // Configuration fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_PINS; n++) begin
        sense_q[n] <= '0;
        prio_q[n]  <= '0;
      end
      mode_q <= 1'b0;
    end else begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (wr_sense) sense_q[n] <= reg_wdata[field_lsb(n, SENSE_W) +: SENSE_W];
        if (wr_prio)  prio_q[n]  <= reg_wdata[field_lsb(n, PRIO_W) +: PRIO_W];
      end
      if (wr_ctrl) mode_q <= reg_wdata[CTRL_MODE_BIT];
    end
  end

  // Masks: set and clear locations, ones act, zeros are ignored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (wr_mset && reg_wdata[src_pos(n, SRC_W)])      mask_q[n] <= 1'b1;
        else if (wr_mclr && reg_wdata[src_pos(n, SRC_W)]) mask_q[n] <= 1'b0;
      end
    end
  end

  // Pending latches: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (evt_vec[n])
          pend_q[n] <= 1'b1;
        else if (wr_src && !reg_wdata[src_pos(n, SRC_W)])
          pend_q[n] <= 1'b0;
      end
    end
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SENSE: for (int n = 0; n < NUM_PINS; n++)
                 reg_rdata[field_lsb(n, SENSE_W) +: SENSE_W] = sense_q[n];
      A_PRIO:  for (int n = 0; n < NUM_PINS; n++)
                 reg_rdata[field_lsb(n, PRIO_W) +: PRIO_W] = prio_q[n];
      A_SRC:   for (int n = 0; n < NUM_PINS; n++)
                 reg_rdata[src_pos(n, SRC_W)] = pend_q[n];
      A_CTRL:  reg_rdata[CTRL_MODE_BIT] = mode_q;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    for (int n = 0; n < NUM_PINS; n++) begin
      code_flat[n*4 +: 4] = 4'(sense_q[n]);
      prio_nz_vec[n]      = |prio_q[n];
    end
  end

  assign pend_vec = pend_q;
  assign mask_vec = mask_q;

endmodule

// File: rtl/extirq_pin_ctrl.sv
module extirq_pin_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int SRC_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                reg_we,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [NUM_PINS-1:0] irq_req,
  output logic                irq_any
);

  logic [NUM_PINS-1:0]   pin_sync;
  logic [NUM_PINS-1:0]   evt_vec;
  logic [NUM_PINS-1:0]   code_valid_vec;
  logic [NUM_PINS*4-1:0] code_flat;
  logic [NUM_PINS-1:0]   pend_vec;
  logic [NUM_PINS-1:0]   mask_vec;
  logic [NUM_PINS-1:0]   prio_nz_vec;

  extirq_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    extirq_detect u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample     (pin_sync[n]),
      .code       (code_flat[n*4 +: 4]),
      .event_hit  (evt_vec[n]),
      .code_valid (code_valid_vec[n])
    );
  end

  extirq_regs #(
    .NUM_PINS (NUM_PINS),
    .SENSE_W  (SENSE_W),
    .SRC_W    (SRC_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .evt_vec     (evt_vec),
    .code_flat   (code_flat),
    .pend_vec    (pend_vec),
    .mask_vec    (mask_vec),
    .prio_nz_vec (prio_nz_vec)
  );

  assign irq_req = pend_vec & ~mask_vec & prio_nz_vec;
  assign irq_any = |irq_req;

endmodule

// File: rtl/extirq_pin_ctrl_chk.sv
module extirq_pin_ctrl_chk
  import extirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SRC_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [2:0]          reg_addr,
  input logic [31:0]         reg_wdata,
  input logic [31:0]         reg_rdata,
  input logic [NUM_PINS-1:0] irq_req,
  input logic [NUM_PINS-1:0] evt_vec,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] code_valid_vec
);

  p_mask_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_MSET || reg_addr == A_MCLR) |-> (reg_rdata == 32'd0));

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_MSET && reg_wdata[SRC_W-1-n]) |=> !irq_req[n]);

    p_prio_zero_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_PRIO && reg_wdata[31-4*n -: 4] == 4'd0)
      |=> !irq_req[n]);

    p_invalid_no_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !code_valid_vec[n] |-> !evt_vec[n]);

    p_pend_needs_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_vec[n]) |-> $past(evt_vec[n]));

    p_clear_works_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_SRC && !reg_wdata[SRC_W-1-n] && !evt_vec[n])
      |=> !pend_vec[n]);

    p_req_needs_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[n] |-> pend_vec[n]);
  end

endmodule

bind extirq_pin_ctrl extirq_pin_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .SRC_W    (SRC_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_we         (reg_we),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .reg_rdata      (reg_rdata),
  .irq_req        (irq_req),
  .evt_vec        (evt_vec),
  .pend_vec       (pend_vec),
  .code_valid_vec (code_valid_vec)
);

// File: tb/tb_extirq_pin_ctrl.sv
`timescale 1ns/1ps
module tb_extirq_pin_ctrl;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '1;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [31:0]   reg_wdata = 32'd0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] irq_req;
  logic          irq_any;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  extirq_pin_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_req   (irq_req),
    .irq_any   (irq_any)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R13 irq_req", 32'(irq_req), 32'd0);
    check("R13 irq_any", 32'(irq_any), 32'd0);
    rd(3'd0, d); check("R13 sense", d, 32'd0);
    rd(3'd1, d); check("R13 prio", d, 32'd0);
    rd(3'd2, d); check("R13 source", d, 32'd0);
    rd(3'd5, d); check("R12 ctrl reset", d, 32'd0);
    // Masked at reset: a falling edge on pin 0 pends but requests nothing
    pin_in[0] = 1'b0;
    wait_n(3);
    rd(3'd2, d); check("R13 pend while masked", d, 32'h80);
    check("R13 masked no req", 32'(irq_req), 32'd0);
    pin_in[0] = 1'b1;
    wr(3'd2, 32'd0);
  endtask

  task automatic t_config;
    logic [31:0] d;
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R8 prio readback", d, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFF);
    check("R9 unmask no pend", 32'(irq_req), 32'd0);
  endtask

  task automatic t_falling;
    logic [31:0] d;
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd0);
    pin_in[0] = 1'b0; pin_in[7] = 1'b0;
    wait_n(2);
    check("R1 not yet after two edges", 32'(irq_req), 32'd0);
    wait_n(1);
    check("R2 falling req", 32'(irq_req), 32'h81);
    check("R11 any", 32'(irq_any), 32'd1);
    rd(3'd2, d); check("R10 source map", d, 32'h81);
    wr(3'd2, 32'hFF);
    rd(3'd2, d); check("R10 write ones keep", d, 32'h81);
    wr(3'd2, 32'h7F);
    rd(3'd2, d); check("R10 clear pin0 only", d, 32'h01);
    check("R11 req pin7 only", 32'(irq_req), 32'h80);
    pin_in[0] = 1'b1; pin_in[7] = 1'b1;
    wait_n(4);
    rd(3'd2, d); check("R2 rising ignored", d, 32'h01);
    wr(3'd2, 32'd0);
    check("R11 any low", 32'(irq_any), 32'd0);
  endtask

  task automatic t_rising;
    logic [31:0] d;
    wr(3'd0, 32'h0100_0000);
    rd(3'd0, d); check("R7 sense pin1 field", d, 32'h0100_0000);
    pin_in[1] = 1'b0;
    wait_n(4);
    rd(3'd2, d); check("R3 falling ignored", d, 32'd0);
    pin_in[1] = 1'b1;
    wait_n(2);
    check("R1 rising not yet", 32'(irq_req), 32'd0);
    wait_n(1);
    check("R3 rising req", 32'(irq_req), 32'h02);
    rd(3'd2, d); check("R3 rising source", d, 32'h40);
    wr(3'd2, 32'd0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(3'd0, 32'h0030_0000);   // pin 2 high level, already high
    wait_n(2);
    rd(3'd2, d); check("R4 high level pend", d, 32'h20);
    wr(3'd2, 32'd0);
    rd(3'd2, d); check("R4 clear while active", d, 32'h20);
    pin_in[2] = 1'b0;
    wait_n(4);
    wr(3'd2, 32'd0);
    rd(3'd2, d); check("R4 clear after inactive", d, 32'd0);
    wr(3'd0, 32'h0002_0000);   // pin 3 low level
    pin_in[3] = 1'b0;
    wait_n(3);
    check("R4 low level req", 32'(irq_req), 32'h08);
    pin_in[3] = 1'b1;
    wait_n(4);
    wr(3'd2, 32'd0);
    rd(3'd2, d); check("R4 low level cleared", d, 32'd0);
    pin_in[2] = 1'b1;
    wait_n(4);
    wr(3'd2, 32'd0);
  endtask

  task automatic t_both;
    logic [31:0] d;
    wr(3'd0, 32'h0000_4000);
    pin_in[4] = 1'b0;
    wait_n(3);
    rd(3'd2, d); check("R5 both falling", d, 32'h08);
    wr(3'd2, 32'd0);
    rd(3'd2, d); check("R5 cleared", d, 32'd0);
    pin_in[4] = 1'b1;
    wait_n(3);
    rd(3'd2, d); check("R5 both rising", d, 32'h08);
    wr(3'd2, 32'd0);
  endtask

  task automatic t_invalid;
    logic [31:0] d;
    wr(3'd0, 32'h0000_0700);
    rd(3'd0, d); check("R7 sense pin5 field", d, 32'h0000_0700);
    pin_in[5] = 1'b0;
    wait_n(4);
    rd(3'd2, d); check("R6 code 7 falling", d, 32'd0);
    pin_in[5] = 1'b1;
    wait_n(4);
    rd(3'd2, d); check("R6 code 7 rising", d, 32'd0);
    wr(3'd0, 32'h0000_0F00);
    pin_in[5] = 1'b0;
    wait_n(4);
    check("R6 code 15 no req", 32'(irq_req), 32'd0);
    pin_in[5] = 1'b1;
    wait_n(4);
    rd(3'd2, d); check("R6 code 15 no pend", d, 32'd0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd0);
    pin_in[0] = 1'b0;
    wait_n(3);
    check("R9 req before mask", 32'(irq_req), 32'h01);
    wr(3'd3, 32'h80);
    check("R9 masked", 32'(irq_req), 32'd0);
    rd(3'd2, d); check("R9 pend kept while masked", d, 32'h80);
    wr(3'd4, 32'h00);
    check("R9 clear zeros no effect", 32'(irq_req), 32'd0);
    rd(3'd3, d); check("R9 mask set reads zero", d, 32'd0);
    rd(3'd4, d); check("R9 mask clear reads zero", d, 32'd0);
    wr(3'd4, 32'h80);
    check("R9 unmasked", 32'(irq_req), 32'h01);
    wr(3'd3, 32'h00);
    check("R9 set zeros no effect", 32'(irq_req), 32'h01);
    pin_in[0] = 1'b1;
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr(3'd1, 32'h0FFF_FFFF);
    check("R8 prio zero blocks", 32'(irq_req), 32'd0);
    rd(3'd1, d); check("R8 prio readback", d, 32'h0FFF_FFFF);
    wr(3'd1, 32'h1FFF_FFFF);
    check("R8 prio one passes", 32'(irq_req), 32'h01);
    wr(3'd2, 32'd0);
    check("R11 cleared", 32'(irq_any), 32'd0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); check("R12 only bit 23", d, 32'h0080_0000);
    wr(3'd5, 32'd0);
    rd(3'd5, d); check("R12 bit cleared", d, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_n(4);
    t_reset;
    t_config;
    t_falling;
    t_rising;
    t_level;
    t_both;
    t_invalid;
    t_mask;
    t_prio;
    t_ctrl;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule